// File: doc/BRIEF.md
# Display Power and Init Sequencer

This block drives a display controller's register port over a write-only SPI link. It holds a fixed table of steps, each either a 16-bit register write, a bare index selection, or a timed pause. A single sequencer walks the table and feeds a small frame shifter and a pause timer. Each register write goes out as two separate 24-bit frames. The first frame carries the register index and the second carries the value. Chip select is released between the two frames.

Three jobs share the table through different start and end steps. A full bring-up runs the whole table. A power-up runs only the supply part. A power-down runs only the leading part that clears the four supply registers. The block keeps the panel's power state and accepts a power request only when that request would change the state. While a job is running, every request is dropped. The shift clock is derived from the core clock so that it never exceeds the register-traffic limit. An optional input sends the bitwise complement of every byte.

Top module: `disp_pwr_seq`

## Requirements
- R1: After reset, `busy` and `pwr_on` are 0, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: A pulse on `init_stb` runs the full bring-up, in this order:
  - write 0x0001 to index 0x00, then pause 10;
  - write 0x0110 to index 0x0C;
  - run the power-up steps of R7;
  - send a lone index frame selecting 0x22.

  `pwr_on` is then 1.
- R3: A register write is an index frame {start, 0x00, index} followed by a data frame {start, value[15:8], value[7:0]}, with chip select high between them. The start byte is 0b01110 followed by the ID bit, the register-select bit (0 for the index frame, 1 for the data frame) and a 0 write bit. With ID=1 the start byte is 0x74 for index frames and 0x76 for data frames.
- R4: SPI uses mode 0, MSB first, 24 bits per frame. Each half period of `spi_sclk` lasts ceil(CLK_HZ / (2*SPI_MAX_HZ)) core cycles, so the shift clock never runs faster than SPI_MAX_HZ.
- R5: A pause of N ticks holds the link idle for at least N*CLK_HZ/TICK_HZ core cycles before the next frame. Frames that are not separated by a pause follow each other within 60 cycles.
- R6: A power request with `req_on`=0 while `pwr_on`=1 runs the power-down steps:
  - 0x0000 to 0x10, pause 10;
  - 0x0000 to 0x11, then 0x0000 to 0x12, pause 40;
  - 0x0000 to 0x13, pause 40.

  `pwr_on` is then cleared.
- R7: A power request with `req_on`=1 while `pwr_on`=0 runs the steps of R6, then:
  - 0x080F to 0x56;
  - 0x4240 to 0x10, pause 10;
  - 0x0000 to 0x11, then 0x0014 to 0x12, pause 40;
  - 0x1319 to 0x13, pause 40.

  `pwr_on` is then set.
- R8: A power request that asks for the current state is dropped: no frame is sent and `busy` stays 0.
- R9: While `busy` is 1, `req_stb` and `init_stb` have no effect on the frames sent or on the final state.
- R10: `busy` rises the cycle after an accepted request and falls only after the last step, including a trailing pause, has finished. `pwr_on` changes only in the cycle that `busy` falls.
- R11: While `tx_invert` is 1, every byte of every frame is sent complemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_stb | input | 1 | One-cycle power request |
| req_on | input | 1 | Requested state with `req_stb` (1 = on) |
| init_stb | input | 1 | One-cycle full bring-up request |
| tx_invert | input | 1 | Send complemented bytes |
| busy | output | 1 | A job is running |
| pwr_on | output | 1 | Current panel power state |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Shift clock, idle low |
| spi_mosi | output | 1 | Serial data out |

## Verification
A wrong step pointer or table entry shows up at the very next frame as a wrong index or value byte on `spi_mosi`, or as a missing or extra frame. A fault in the pause timer appears as a gap between chip-select pulses that is too short or too long, and this is visible within one pause length. A fault in the acceptance logic or the power state shows up as frames on a request that should be dropped, or as a wrong `pwr_on` level once `busy` falls. Each job's frames are captured from the pins and compared, byte by byte and gap by gap, with the step list stated in the requirements.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [1:0] {K_WRITE, K_WAIT, K_INDEX} kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [7:0]  idx;
    logic [15:0] arg;   // write value, or pause length in ticks
  } step_t;

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_IDXF, S_DATA, S_DATF, S_WAIT} seq_e;

  localparam int unsigned PCW = 5;
  localparam logic [PCW-1:0] PC_INIT     = 5'd0;
  localparam logic [PCW-1:0] PC_PWR      = 5'd3;
  localparam logic [PCW-1:0] PC_OFF_END  = 5'd9;
  localparam logic [PCW-1:0] PC_ON_END   = 5'd17;
  localparam logic [PCW-1:0] PC_INIT_END = 5'd18;

  function automatic step_t step_at(input logic [PCW-1:0] pc);
    step_t s;
    case (pc)
      5'd0:  s = '{K_WRITE, 8'h00, 16'h0001};
      5'd1:  s = '{K_WAIT,  8'h00, 16'd10};
      5'd2:  s = '{K_WRITE, 8'h0C, 16'h0110};
      5'd3:  s = '{K_WRITE, 8'h10, 16'h0000};
      5'd4:  s = '{K_WAIT,  8'h00, 16'd10};
      5'd5:  s = '{K_WRITE, 8'h11, 16'h0000};
      5'd6:  s = '{K_WRITE, 8'h12, 16'h0000};
      5'd7:  s = '{K_WAIT,  8'h00, 16'd40};
      5'd8:  s = '{K_WRITE, 8'h13, 16'h0000};
      5'd9:  s = '{K_WAIT,  8'h00, 16'd40};
      5'd10: s = '{K_WRITE, 8'h56, 16'h080F};
      5'd11: s = '{K_WRITE, 8'h10, 16'h4240};
      5'd12: s = '{K_WAIT,  8'h00, 16'd10};
      5'd13: s = '{K_WRITE, 8'h11, 16'h0000};
      5'd14: s = '{K_WRITE, 8'h12, 16'h0014};
      5'd15: s = '{K_WAIT,  8'h00, 16'd40};
      5'd16: s = '{K_WRITE, 8'h13, 16'h1319};
      5'd17: s = '{K_WAIT,  8'h00, 16'd40};
      5'd18: s = '{K_INDEX, 8'h22, 16'h0000};
      default: s = '{K_WAIT, 8'h00, 16'd1};
    endcase
    return s;
  endfunction

  function automatic logic [7:0] start_byte(input logic id, input logic rs);
    return {5'b01110, id, rs, 1'b0};
  endfunction

endpackage

// File: rtl/dps_tick_timer.sv
module dps_tick_timer #(
  parameter int unsigned TICK_CYC = 125000,
  parameter int unsigned CW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] count,
  output logic          running,
  output logic          done
);
  localparam int unsigned PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(TICK_CYC - 1);

  logic [PW-1:0] pre;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre     <= '0;
      left    <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        pre     <= PRE_TOP;
        left    <= count;
        running <= 1'b1;
      end else if (running) begin
        if (pre != '0) begin
          pre <= pre - 1'b1;
        end else begin
          pre <= PRE_TOP;
          if (left <= CW'(1)) begin
            running <= 1'b0;
            done    <= 1'b1;
          end else begin
            left <= left - 1'b1;
          end
        end
      end
    end
  end

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running);  // R5
endmodule

// File: rtl/dps_spi_frame.sv
module dps_spi_frame #(
  parameter int unsigned HALF = 16,
  parameter int unsigned W    = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] word,
  input  logic         invert,
  output logic         done,
  output logic         cs_n,
  output logic         sclk,
  output logic         mosi
);
  localparam int unsigned HW = $clog2(HALF + 1);
  localparam int unsigned BW = $clog2(W);
  localparam logic [HW-1:0] H_TOP = HW'(HALF - 1);
  localparam logic [BW-1:0] B_TOP = BW'(W - 1);

  typedef enum logic [1:0] {F_IDLE, F_SHIFT, F_GAP} fst_e;
  fst_e          fst;
  logic [HW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [W-1:0]  sh;

  assign mosi = sh[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fst  <= F_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      cs_n <= 1'b1;
      sclk <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (fst)
        F_IDLE: if (start) begin
          sh   <= word ^ {W{invert}};
          cs_n <= 1'b0;
          sclk <= 1'b0;
          cnt  <= H_TOP;
          bitn <= '0;
          fst  <= F_SHIFT;
        end
        F_SHIFT: if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= H_TOP;
          if (!sclk) begin
            sclk <= 1'b1;
          end else begin
            sclk <= 1'b0;
            if (bitn == B_TOP) begin
              cs_n <= 1'b1;
              fst  <= F_GAP;
            end else begin
              sh   <= {sh[W-2:0], 1'b0};
              bitn <= bitn + 1'b1;
            end
          end
        end
        F_GAP: if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          fst  <= F_IDLE;
          done <= 1'b1;
        end
        default: fst <= F_IDLE;
      endcase
    end
  end

  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);  // R4
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));  // R4
endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq #(
  parameter int unsigned CLK_HZ     = 125000000,
  parameter int unsigned TICK_HZ    = 1000,
  parameter int unsigned SPI_MAX_HZ = 4000000,
  parameter bit          DEV_ID     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_stb,
  input  logic req_on,
  input  logic init_stb,
  input  logic tx_invert,
  output logic busy,
  output logic pwr_on,
  output logic spi_cs_n,
  output logic spi_sclk,
  output logic spi_mosi
);
  import dps_pkg::*;

  localparam int unsigned HALF_RAW = (CLK_HZ + 2*SPI_MAX_HZ - 1) / (2*SPI_MAX_HZ);
  localparam int unsigned HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int unsigned TICK_RAW = CLK_HZ / TICK_HZ;
  localparam int unsigned TICK_CYC = (TICK_RAW < 1) ? 1 : TICK_RAW;
  localparam int unsigned FW       = 24;

  seq_e           st;
  logic [PCW-1:0] pc, last;
  logic           target;
  step_t          cur;
  logic           frm_start, frm_done, tm_load, tm_done, tm_run, step_fin;
  logic [FW-1:0]  frm_word;

  assign cur       = step_at(pc);
  assign busy      = (st != S_IDLE);
  assign frm_start = (st == S_STEP && cur.kind != K_WAIT) || (st == S_DATA);
  assign frm_word  = (st == S_DATA) ? {start_byte(DEV_ID, 1'b1), cur.arg}
                                    : {start_byte(DEV_ID, 1'b0), 8'h00, cur.idx};
  assign tm_load   = (st == S_STEP) && (cur.kind == K_WAIT);
  assign step_fin  = (st == S_IDXF && frm_done && cur.kind != K_WRITE) ||
                     (st == S_DATF && frm_done) ||
                     (st == S_WAIT && tm_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pc     <= '0;
      last   <= '0;
      target <= 1'b0;
      pwr_on <= 1'b0;
    end else if (step_fin) begin
      if (pc == last) begin
        st     <= S_IDLE;
        pwr_on <= target;
      end else begin
        pc <= pc + 1'b1;
        st <= S_STEP;
      end
    end else begin
      case (st)
        S_IDLE: if (init_stb) begin
          pc <= PC_INIT; last <= PC_INIT_END; target <= 1'b1; st <= S_STEP;
        end else if (req_stb && (req_on != pwr_on)) begin
          pc <= PC_PWR; last <= req_on ? PC_ON_END : PC_OFF_END;
          target <= req_on; st <= S_STEP;
        end
        S_STEP:  st <= (cur.kind == K_WAIT) ? S_WAIT : S_IDXF;
        S_IDXF:  if (frm_done) st <= S_DATA;
        S_DATA:  st <= S_DATF;
        default: ;
      endcase
    end
  end

  dps_spi_frame #(.HALF(HALF), .W(FW)) u_frame (
    .clk(clk), .rst_n(rst_n), .start(frm_start), .word(frm_word),
    .invert(tx_invert), .done(frm_done), .cs_n(spi_cs_n),
    .sclk(spi_sclk), .mosi(spi_mosi)
  );

  dps_tick_timer #(.TICK_CYC(TICK_CYC), .CW(16)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .count(cur.arg),
    .running(tm_run), .done(tm_done)
  );

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);  // R10
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pwr_on));  // R10
  AST_NO_FRAME_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tm_run |-> spi_cs_n);  // R5
  AST_ACCEPT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(init_stb)) |-> $past(req_stb && (req_on != pwr_on)));  // R8
endmodule

// File: tb/test_disp_pwr_seq.sv
`timescale 1ns/1ps
module test_disp_pwr_seq;
  localparam longint TICK = 125;   // cycles per tick with the overrides below

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_stb = 1'b0, req_on = 1'b0, init_stb = 1'b0, tx_invert = 1'b0;
  logic busy, pwr_on, spi_cs_n, spi_sclk, spi_mosi;

  always #4 clk = ~clk;

  disp_pwr_seq #(.CLK_HZ(125000000), .TICK_HZ(1000000), .SPI_MAX_HZ(4000000), .DEV_ID(1'b1))
  i_disp_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_on(req_on), .init_stb(init_stb),
    .tx_invert(tx_invert), .busy(busy), .pwr_on(pwr_on), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
  );

  // step table: [31:24] kind (0 write, 1 pause, 2 index only), [23:16] index, [15:0] value/ticks
  localparam logic [31:0] SEQ [0:18] = '{
    {8'd0, 8'h00, 16'h0001}, {8'd1, 8'h00, 16'd10}, {8'd0, 8'h0C, 16'h0110},
    {8'd0, 8'h10, 16'h0000}, {8'd1, 8'h00, 16'd10}, {8'd0, 8'h11, 16'h0000},
    {8'd0, 8'h12, 16'h0000}, {8'd1, 8'h00, 16'd40}, {8'd0, 8'h13, 16'h0000},
    {8'd1, 8'h00, 16'd40},   {8'd0, 8'h56, 16'h080F}, {8'd0, 8'h10, 16'h4240},
    {8'd1, 8'h00, 16'd10},   {8'd0, 8'h11, 16'h0000}, {8'd0, 8'h12, 16'h0014},
    {8'd1, 8'h00, 16'd40},   {8'd0, 8'h13, 16'h1319}, {8'd1, 8'h00, 16'd40},
    {8'd2, 8'h22, 16'h0000}
  };

  // frame capture from the pins
  logic [23:0] fr_data [0:63];
  int          fr_bits [0:63];
  longint      fr_t0 [0:63];
  longint      fr_t1 [0:63];
  int          fr_n = 0;
  logic [23:0] cur_w = '0;
  int          cur_b = 0;
  bit          armed = 0, have_prev = 0;
  longint      t_fall = 0, t_prev = 0, min_per = 1000000, t_bfall = 0;

  always @(negedge spi_cs_n) begin
    t_fall = $time; cur_b = 0; have_prev = 0; armed = 1;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    cur_w = {cur_w[22:0], spi_mosi};
    cur_b++;
    if (have_prev && ($time - t_prev) < min_per) min_per = $time - t_prev;
    t_prev = $time; have_prev = 1;
  end
  always @(posedge spi_cs_n) if (armed && fr_n < 64) begin
    fr_data[fr_n] = cur_w; fr_bits[fr_n] = cur_b;
    fr_t0[fr_n] = t_fall; fr_t1[fr_n] = $time; fr_n++; armed = 0;
  end
  always @(negedge busy) t_bfall = $time;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic pulse(input bit is_init, input bit on);
    @(negedge clk);
    if (is_init) init_stb = 1'b1; else begin req_stb = 1'b1; req_on = on; end
    @(negedge clk);
    init_stb = 1'b0; req_stb = 1'b0;
  endtask

  task automatic wait_idle();   // doubles as watchdog
    for (int i = 0; i < 80000; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
    chk(1'b0, "watchdog", 1, 0);
    finish_run();
  endtask

  task automatic check_seq(input int first, input int last, input bit inv, input int base, input string tag);
    int     k = base;
    longint pw = 0, gap;
    logic [23:0] m = {24{inv}};
    for (int e = first; e <= last; e++) begin
      if (SEQ[e][31:24] == 8'd1) begin
        pw += longint'(SEQ[e][15:0]);
      end else begin
        chk(fr_data[k] == ({8'h74, 8'h00, SEQ[e][23:16]} ^ m), tag, fr_data[k],
            {8'h74, 8'h00, SEQ[e][23:16]} ^ m);
        chk(fr_bits[k] == 24, "R4", fr_bits[k], 24);
        if (k > base) begin
          gap = (fr_t0[k] - fr_t1[k-1]) / 8;
          if (pw > 0) chk(gap >= pw*TICK && gap <= pw*TICK + 60, "R5", gap, pw*TICK);
          else        chk(gap < 60, "R5", gap, 0);
        end
        pw = 0; k++;
        if (SEQ[e][31:24] == 8'd0) begin
          chk(fr_data[k] == ({8'h76, SEQ[e][15:0]} ^ m), tag, fr_data[k], {8'h76, SEQ[e][15:0]} ^ m);
          gap = (fr_t0[k] - fr_t1[k-1]) / 8;
          chk(gap > 0 && gap < 60, "R3", gap, 0);
          k++;
        end
      end
    end
    if (pw > 0) chk((t_bfall - fr_t1[k-1]) / 8 >= pw*TICK, "R10", (t_bfall - fr_t1[k-1]) / 8, pw*TICK);
    chk(fr_n == k, "R2", fr_n - base, k - base);
  endtask

  initial begin
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", busy, 0);
    chk(pwr_on == 1'b0, "R1", pwr_on, 0);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", {spi_cs_n, spi_sclk}, 2'b10);

    // R8 off request while off is dropped
    pulse(1'b0, 1'b0);
    repeat (300) @(negedge clk);
    chk(busy == 1'b0 && fr_n == 0, "R8", fr_n, 0);

    // R2 full bring-up, with R9 requests during it
    base = fr_n;
    pulse(1'b1, 1'b0);
    repeat (1000) @(negedge clk);
    chk(busy == 1'b1, "R10", busy, 1);
    chk(pwr_on == 1'b0, "R10", pwr_on, 0);
    pulse(1'b0, 1'b0);
    pulse(1'b1, 1'b0);  // R9
    wait_idle();
    check_seq(0, 18, 1'b0, base, "R2");
    chk(pwr_on == 1'b1, "R2", pwr_on, 1);

    // R8 on request while on is dropped
    base = fr_n;
    pulse(1'b0, 1'b1);
    repeat (300) @(negedge clk);
    chk(busy == 1'b0 && fr_n == base, "R8", fr_n - base, 0);

    // R6 power-down with R11 complemented bytes
    tx_invert = 1'b1;
    base = fr_n;
    pulse(1'b0, 1'b0);
    chk(busy == 1'b1, "R6", busy, 1);
    wait_idle();
    check_seq(3, 9, 1'b1, base, "R11");
    chk(pwr_on == 1'b0, "R6", pwr_on, 0);
    tx_invert = 1'b0;

    // R7 power-up
    base = fr_n;
    pulse(1'b0, 1'b1);
    wait_idle();
    check_seq(3, 17, 1'b0, base, "R7");
    chk(pwr_on == 1'b1, "R7", pwr_on, 1);

    // R4 shift clock no faster than 4 MHz (250 ns period)
    chk(min_per >= 250, "R4", min_per, 256);
    finish_run();
  end
endmodule